// File: doc/BRIEF.md
# Standby Mode Entry Controller

This block sits between a processor core and its peripheral interrupt sources. It holds the low-power mode selection and drives two clock enables from it: one for the core and one for the peripherals. The core asks for a low-power state by writing a control byte. The block turns that write down without any notice if a peripheral request that qualifies for service is pending at that moment. It does this whether or not the core could currently accept that request.

While in a low-power state, any qualifying request returns the block to active mode on the next clock edge. Wake-up does not depend on the core's interrupt enable or mask level. On the edge that wakes the block, it decides whether the core should branch to the interrupt routine or carry on with the instruction after the one that requested standby. It makes this decision by comparing the priority level of each waking source with the core's mask level and enable flag.

Each of the N_SRC sources provides a request flag and a 2-bit priority level. The level value 3 marks a disabled source. A numerically smaller level has higher priority.

Top module: `standby_ctrl`

## Requirements
- R1: After reset the mode output is 00 (active), rd_data reads 8'h00, both clock enables are 1 and take_irq is 0.
- R2: In active mode, a write whose bit 6 is 1 and bit 7 is 0 moves the mode to 01 (sleep) on the next clock edge, provided no qualifying request is pending. In sleep, core_clk_en is 0 and periph_clk_en is 1.
- R3: In active mode, a write whose bit 7 is 1 moves the mode to 10 (stop) on the next edge, provided no qualifying request is pending. In stop, both clock enables are 0.
- R4: A write with both bit 7 and bit 6 set selects stop, not sleep.
- R5: A standby write is ignored while any source has its flag set and a level other than 3. The block stays active and rd_data stays 8'h00, whatever the values of cpu_ie and cpu_mask. Once such flags are cleared, the same write takes effect.
- R6: A source whose level is 3 never qualifies. Its flag neither blocks standby entry nor wakes the block from sleep or stop.
- R7: In sleep or stop, any qualifying request returns the mode to 00 on the next edge, independent of cpu_ie and cpu_mask. rd_data then reads 8'h00.
- R8: take_irq is a one-cycle pulse that coincides with the first active cycle after a wake. It is 1 only if cpu_ie is 1 and at least one waking source has a level numerically below cpu_mask. In every other cycle it is 0.
- R9: In active mode, a write with bits 7 and 6 both 0 leaves the mode at active.
- R10: rd_data carries the stop state at bit 7 and the sleep state at bit 6. Bits 5..0 always read 0, whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte (bit 7 stop, bit 6 sleep) |
| rd_data | output | 8 | Control byte read value |
| req_flag | input | N_SRC | Per-source pending request flags |
| req_lvl | input | 2*N_SRC | Per-source 2-bit priority levels, source i at [2i+1:2i] |
| cpu_mask | input | 2 | Core's current mask level |
| cpu_ie | input | 1 | Core's interrupt enable flag |
| mode | output | 2 | 00 active, 01 sleep, 10 stop |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| take_irq | output | 1 | Branch to interrupt routine after wake-up |

## Verification
The bench covers four cases:
- A standby write made while a request is pending and the core has interrupts disabled. A design that consulted cpu_ie would enter standby here.
- A write with both mode bits set. A wrong design would pick sleep and leave the peripheral clock running.
- Wakes caused by sources whose level does not beat the mask, or while the enable flag is clear. A faulty design would either not wake at all or raise take_irq wrongly.
- A flagged source at level 3. A wrong design would let it block entry or cause a spurious wake.

// File: rtl/stby_pkg.sv
package stby_pkg;
  localparam int LVL_W = 2;
  localparam logic [LVL_W-1:0] LVL_OFF = '1;

  typedef enum logic [1:0] {
    MODE_ACTIVE = 2'b00,
    MODE_SLEEP  = 2'b01,
    MODE_STOP   = 2'b10
  } stby_mode_e;

  // a source can be serviced unless its level is the disabled code
  function automatic logic lvl_live(input logic [LVL_W-1:0] lvl);
    return lvl != LVL_OFF;
  endfunction

  // smaller value is higher priority
  function automatic logic lvl_beats(input logic [LVL_W-1:0] lvl,
                                     input logic [LVL_W-1:0] mask);
    return lvl < mask;
  endfunction

  // stop wins when both bits are set
  function automatic stby_mode_e decode_req(input logic stp, input logic slp);
    if (stp)      return MODE_STOP;
    else if (slp) return MODE_SLEEP;
    else          return MODE_ACTIVE;
  endfunction
endpackage

// File: rtl/stby_req_scan.sv
module stby_req_scan
  import stby_pkg::*;
#(
  parameter int N_SRC = 4
) (
  input  logic [N_SRC-1:0]       req_flag,
  input  logic [N_SRC*LVL_W-1:0] req_lvl,
  input  logic [LVL_W-1:0]       cpu_mask,
  input  logic                   cpu_ie,
  output logic                   any_live,
  output logic                   any_beat
);
  logic [N_SRC-1:0] live_v;
  logic [N_SRC-1:0] beat_v;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic [LVL_W-1:0] lvl_i;
    assign lvl_i     = req_lvl[i*LVL_W +: LVL_W];
    assign live_v[i] = req_flag[i] && lvl_live(lvl_i);
    assign beat_v[i] = live_v[i] && lvl_beats(lvl_i, cpu_mask);
  end

  assign any_live = |live_v;
  assign any_beat = cpu_ie && (|beat_v);
endmodule

// File: rtl/stby_mode_reg.sv
module stby_mode_reg
  import stby_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_stop,
  input  logic       wr_sleep,
  input  logic       any_live,
  input  logic       any_beat,
  output stby_mode_e mode_q,
  output logic       take_q,
  output logic       enter_evt,
  output logic       refuse_evt,
  output logic       wake_evt
);
  stby_mode_e mode_d;
  logic       want_lp;

  assign want_lp    = wr_en && (wr_stop || wr_sleep);
  assign enter_evt  = (mode_q == MODE_ACTIVE) && want_lp && !any_live;
  assign refuse_evt = (mode_q == MODE_ACTIVE) && want_lp && any_live;
  assign wake_evt   = (mode_q != MODE_ACTIVE) && any_live;

  always_comb begin
    mode_d = mode_q;
    if (enter_evt)     mode_d = decode_req(wr_stop, wr_sleep);
    else if (wake_evt) mode_d = MODE_ACTIVE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_ACTIVE;
      take_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      take_q <= wake_evt && any_beat;
    end
  end
endmodule

// File: rtl/standby_ctrl.sv
module standby_ctrl
  import stby_pkg::*;
#(
  parameter int N_SRC     = 4,
  parameter int DATA_W    = 8,
  parameter int STOP_POS  = 7,
  parameter int SLEEP_POS = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [DATA_W-1:0]      wr_data,
  output logic [DATA_W-1:0]      rd_data,
  input  logic [N_SRC-1:0]       req_flag,
  input  logic [N_SRC*LVL_W-1:0] req_lvl,
  input  logic [LVL_W-1:0]       cpu_mask,
  input  logic                   cpu_ie,
  output logic [1:0]             mode,
  output logic                   core_clk_en,
  output logic                   periph_clk_en,
  output logic                   take_irq
);
  logic       any_live;
  logic       any_beat;
  logic       enter_evt;
  logic       refuse_evt;
  logic       wake_evt;
  stby_mode_e mode_q;

  stby_req_scan #(.N_SRC(N_SRC)) u_scan (
    .req_flag (req_flag),
    .req_lvl  (req_lvl),
    .cpu_mask (cpu_mask),
    .cpu_ie   (cpu_ie),
    .any_live (any_live),
    .any_beat (any_beat)
  );

  stby_mode_reg u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_stop    (wr_data[STOP_POS]),
    .wr_sleep   (wr_data[SLEEP_POS]),
    .any_live   (any_live),
    .any_beat   (any_beat),
    .mode_q     (mode_q),
    .take_q     (take_irq),
    .enter_evt  (enter_evt),
    .refuse_evt (refuse_evt),
    .wake_evt   (wake_evt)
  );

  always_comb begin
    rd_data            = '0;
    rd_data[STOP_POS]  = (mode_q == MODE_STOP);
    rd_data[SLEEP_POS] = (mode_q == MODE_SLEEP);
  end

  assign mode          = mode_q;
  assign core_clk_en   = (mode_q == MODE_ACTIVE);
  assign periph_clk_en = (mode_q != MODE_STOP);
endmodule

// File: rtl/standby_ctrl_chk.sv
module standby_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [1:0] mode,
  input logic       core_clk_en,
  input logic       periph_clk_en,
  input logic       take_irq,
  input logic       any_live,
  input logic       refuse_evt
);
  AST_REFUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    refuse_evt |=> (mode == 2'b00)); // R5
  AST_WAKE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b00 && any_live) |=> (mode == 2'b00)); // R7
  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && wr_en && wr_data[7] && !any_live) |=> (mode == 2'b10)); // R4
  AST_CORE_NEEDS_PERIPH: assert property (@(posedge clk) disable iff (!rst_n)
    core_clk_en |-> periph_clk_en); // R3
  AST_TAKE_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> ($past(mode) != 2'b00 && mode == 2'b00)); // R8
  AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |=> !take_irq); // R8
endmodule

bind standby_ctrl standby_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_en         (wr_en),
  .wr_data       (wr_data),
  .mode          (mode),
  .core_clk_en   (core_clk_en),
  .periph_clk_en (periph_clk_en),
  .take_irq      (take_irq),
  .any_live      (any_live),
  .refuse_evt    (refuse_evt)
);

// File: tb/standby_ctrl_bench.sv
`timescale 1ns/1ps
module standby_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [3:0] req_flag = 4'h0;
  logic [7:0] req_lvl = 8'hFF;
  logic [1:0] cpu_mask = 2'b11;
  logic       cpu_ie = 1'b1;
  logic [1:0] mode;
  logic       core_clk_en, periph_clk_en, take_irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  string tag = "R1";

  int m_mode = 0;
  bit m_take = 1'b0;

  always #5 clk = ~clk;

  standby_ctrl u_standby_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .req_flag(req_flag), .req_lvl(req_lvl), .cpu_mask(cpu_mask), .cpu_ie(cpu_ie),
    .mode(mode), .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
    .take_irq(take_irq)
  );

  // behavioural reference, updated on each rising edge from the settled inputs
  always @(posedge clk or negedge rst_n) begin
    bit pend, win;
    pend = 1'b0; win = 1'b0;
    for (int i = 0; i < 4; i++) begin
      int lv;
      lv = req_lvl[2*i +: 2];
      if (req_flag[i] && lv != 3) begin
        pend = 1'b1;
        if (cpu_ie && lv < int'(cpu_mask)) win = 1'b1;
      end
    end
    if (!rst_n) begin
      m_mode = 0; m_take = 1'b0;
    end else begin
      m_take = 1'b0;
      if (m_mode == 0) begin
        if (wr_en && !pend) begin
          if (wr_data[7])      m_mode = 2;
          else if (wr_data[6]) m_mode = 1;
        end
      end else if (pend) begin
        m_take = win;
        m_mode = 0;
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [7:0] e_rd;
      e_rd = (m_mode == 2) ? 8'h80 : (m_mode == 1) ? 8'h40 : 8'h00;
      checks++;
      if (mode != m_mode[1:0] || rd_data != e_rd || take_irq != m_take ||
          core_clk_en != (m_mode == 0) || periph_clk_en != (m_mode != 2)) begin
        failures++;
        $display("FAIL %s: mode=%0d rd=%h take=%0b cce=%0b pce=%0b exp mode=%0d rd=%h take=%0b",
                 tag, mode, rd_data, take_irq, core_clk_en, periph_clk_en, m_mode, e_rd, m_take);
      end
    end
  end

  task automatic chk(input string t, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    step(1);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic set_src(input int i, input bit f, input logic [1:0] lv);
    req_flag[i] = f;
    req_lvl[2*i +: 2] = lv;
  endtask

  initial begin
    step(2);
    rst_n = 1'b1;
    step(1);
    tag = "R1";
    chk("R1 mode", {6'b0, mode}, 8'h00);
    chk("R1 rd", rd_data, 8'h00);
    chk("R1 enables", {6'b0, core_clk_en, periph_clk_en}, 8'h03);
    chk("R1 take", {7'b0, take_irq}, 8'h00);

    tag = "R2";
    wr(8'h40);
    chk("R2 mode", {6'b0, mode}, 8'h01);
    chk("R2 enables", {6'b0, core_clk_en, periph_clk_en}, 8'h01);
    chk("R10 sleep read", rd_data, 8'h40);
    step(3);
    tag = "R8";
    cpu_mask = 2'b11; cpu_ie = 1'b1;
    set_src(2, 1'b1, 2'b01);
    step(1);
    chk("R7 wake", {6'b0, mode}, 8'h00);
    chk("R8 take beats", {7'b0, take_irq}, 8'h01);
    step(1);
    chk("R8 pulse ends", {7'b0, take_irq}, 8'h00);
    set_src(2, 1'b0, 2'b11);
    step(1);

    tag = "R3";
    wr(8'h80);
    chk("R3 mode", {6'b0, mode}, 8'h02);
    chk("R3 enables", {6'b0, core_clk_en, periph_clk_en}, 8'h00);
    chk("R10 stop read", rd_data, 8'h80);
    step(2);
    tag = "R7";
    cpu_ie = 1'b0;
    set_src(0, 1'b1, 2'b10);
    step(1);
    chk("R7 wake ie=0", {6'b0, mode}, 8'h00);
    chk("R8 no take ie=0", {7'b0, take_irq}, 8'h00);
    chk("R7 read after wake", rd_data, 8'h00);
    set_src(0, 1'b0, 2'b11);
    cpu_ie = 1'b1;
    step(1);

    tag = "R4";
    wr(8'hC0);
    chk("R4 stop wins", {6'b0, mode}, 8'h02);
    cpu_mask = 2'b01;
    set_src(1, 1'b1, 2'b10);
    step(1);
    chk("R8 no take level", {7'b0, take_irq}, 8'h00);
    set_src(1, 1'b0, 2'b11);
    step(1);

    tag = "R5";
    cpu_ie = 1'b0; cpu_mask = 2'b00;
    set_src(3, 1'b1, 2'b00);
    step(1);
    wr(8'h40);
    chk("R5 refused ie=0", {6'b0, mode}, 8'h00);
    chk("R5 read", rd_data, 8'h00);
    cpu_ie = 1'b1; cpu_mask = 2'b11;
    wr(8'h80);
    chk("R5 refused ie=1", {6'b0, mode}, 8'h00);
    set_src(3, 1'b0, 2'b00);
    step(1);
    wr(8'h80);
    chk("R5 allowed after clear", {6'b0, mode}, 8'h02);
    set_src(3, 1'b1, 2'b00);
    step(1);
    set_src(3, 1'b0, 2'b11);
    step(1);

    tag = "R6";
    set_src(0, 1'b1, 2'b11);
    step(1);
    wr(8'h40);
    chk("R6 disabled not blocking", {6'b0, mode}, 8'h01);
    set_src(1, 1'b1, 2'b11);
    step(3);
    chk("R6 disabled no wake", {6'b0, mode}, 8'h01);
    set_src(2, 1'b1, 2'b00);
    step(1);
    chk("R6 live wakes", {6'b0, mode}, 8'h00);
    req_flag = 4'h0; req_lvl = 8'hFF;
    step(1);

    tag = "R9";
    wr(8'h00);
    chk("R9 stays active", {6'b0, mode}, 8'h00);
    tag = "R10";
    wr(8'h3F);
    chk("R10 low bits", rd_data, 8'h00);
    chk("R10 mode", {6'b0, mode}, 8'h00);
    step(2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule